// File: doc/BRIEF.md
# Whole-Cycle Period Window Checker

This block times a programmable whole number of periods of a square-wave input against the system clock and decides whether the total lies inside a preloaded acceptance band. A start pulse samples three load values: the lower limit of the band, the upper limit of the band and the number of input periods to total over. The gate opens on the first rising input edge after that pulse and closes on the rising edge that completes the programmed number of periods. Measuring over whole periods gives fine resolution for slow signals without ever working out a frequency.

When the gate closes, the total is compared with the band. A total above the upper limit means the input is too slow, and the block raises its tune-up flag. A total below the lower limit means the input is too fast, and it raises its tune-down flag. Otherwise it raises the in-band flag. The flags are registered, they hold until the next result, and they are suitable for driving indicator lamps directly. A one-cycle done strobe marks each new result. The elapsed-time counter saturates, and a saturated total counts as too slow.

Top module: `recip_window_cmp`

## Requirements
- R1: After reset, tune_up, tune_down, in_band and done are all low.
- R2: The total equals the number of clock cycles from the first rising edge of sig_in detected after an accepted start to the rising edge that completes the programmed number of whole input periods. For a steady period of P clocks and N periods, the total is N*P.
- R3: A cycle count of zero loaded at start is treated as one period.
- R4: A total strictly greater than the upper limit sets tune_up=1, tune_down=0, in_band=0.
- R5: A total strictly less than the lower limit, when it is not above the upper limit, sets tune_down=1, tune_up=0, in_band=0.
- R6: A total with lower limit <= total <= upper limit sets in_band=1 and clears both tune flags. Both limits are inclusive.
- R7: The elapsed-time counter stops at its all-ones value (2^CNT_W-1). A saturated total always sets tune_up, even when the upper limit is all ones.
- R8: Each completed measurement gives exactly one done pulse, one clock cycle long, and exactly one of the three flags is high from that pulse onward.
- R9: The three flags keep their values between done pulses.
- R10: A start pulse while a measurement is armed or running is ignored. The limits and the cycle count used are those sampled at the accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Square-wave input, asynchronous to clk |
| start | input | 1 | Begins a measurement when the block is idle |
| min_cnt | input | CNT_W | Lower limit of the acceptance band, in clock cycles |
| max_cnt | input | CNT_W | Upper limit of the acceptance band, in clock cycles |
| cyc_num | input | CYC_W | Number of whole input periods to total over |
| tune_up | output | 1 | Total above the band or saturated (input too slow) |
| tune_down | output | 1 | Total below the band (input too fast) |
| in_band | output | 1 | Total inside the band |
| done | output | 1 | One-cycle strobe when a result is written |

## Verification
The assertions assume that sig_in stays at each level for at least one clock cycle, so that two detected rising edges are never adjacent. They also assume that start is only meaningful while the block is idle. The bench drives square waves with periods of four clocks or more, changes inputs only on falling clock edges, and pulses start during a running measurement with conflicting loads to show that such a pulse is ignored. Random periods and cycle counts keep the totals well below the saturation value, and a single directed long-period run reaches saturation on purpose.

// File: rtl/rwc_pkg.sv
// Package: shared types for the whole-cycle period window checker.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package rwc_pkg;
    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,
        GATE_ARM  = 2'd1,
        GATE_RUN  = 2'd2
    } gate_st_e;
endpackage

// File: rtl/rwc_edge.sv
// rwc_edge: brings the asynchronous square wave into the clock domain through
// SYNC_STAGES flops and flags a rising edge for one cycle.
// Assumes the input holds each level for at least one clock cycle.
module rwc_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;

    // Shift the input through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SH_W-2:0], sig_in};
    end

    // Rising edge: newest synchronised sample high, the one before it low.
    always_comb rise = sh_q[SH_W-2] & ~sh_q[SH_W-1];

    // R2
    rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/rwc_gate.sv
// rwc_gate: gate sequencer. It accepts start only when idle, arms on the next
// rising edge and counts rising edges until the programmed number of whole
// periods is complete. A zero cycle count is treated as one.
// Assumes rise is a one-cycle pulse.
module rwc_gate #(
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CYC_W-1:0] cyc_num,
    input  logic             rise,
    output logic             load,
    output logic             arm_hit,
    output logic             run,
    output logic             finish
);
    import rwc_pkg::*;

    gate_st_e         st_q;
    logic [CYC_W-1:0] cyc_q;
    logic [CYC_W-1:0] ecnt_q;
    logic [CYC_W:0]   ecnt_nx;

    // Decode the strobes that drive the counter and the judge.
    always_comb begin
        ecnt_nx = {1'b0, ecnt_q} + 1'b1;
        load    = (st_q == GATE_IDLE) && start;
        arm_hit = (st_q == GATE_ARM) && rise;
        run     = (st_q == GATE_RUN);
        finish  = run && rise && (ecnt_nx >= {1'b0, cyc_q});
    end

    // State, captured cycle count and edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= GATE_IDLE;
            cyc_q  <= '0;
            ecnt_q <= '0;
        end else begin
            unique case (st_q)
                GATE_IDLE: if (start) begin
                    st_q  <= GATE_ARM;
                    cyc_q <= (cyc_num == '0) ? CYC_W'(1) : cyc_num;
                end
                GATE_ARM: if (rise) begin
                    st_q   <= GATE_RUN;
                    ecnt_q <= '0;
                end
                GATE_RUN: if (rise) begin
                    if (finish) st_q   <= GATE_IDLE;
                    else        ecnt_q <= ecnt_nx[CYC_W-1:0];
                end
                default: st_q <= GATE_IDLE;
            endcase
        end
    end

    // R10
    cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != GATE_IDLE) |=> $stable(cyc_q));
    // R2
    edge_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ecnt_q < cyc_q));
    // R3
    cyc_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != GATE_IDLE) |-> (cyc_q != '0));
endmodule

// File: rtl/rwc_elapsed.sv
// rwc_elapsed: saturating elapsed-time counter. Clear sets it to zero and
// inc adds one, stopping at all ones. tot is the value after this cycle's
// increment and feeds the judge in the closing cycle.
// Assumes clr and inc are never high together.
module rwc_elapsed #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] tot,
    output logic             sat
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    // Next count with saturation at the top value.
    always_comb begin
        tot = (cnt_q == TOP) ? TOP : cnt_q + 1'b1;
        sat = (tot == TOP);
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= tot;
    end

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt_q == TOP) |=> (cnt_q == TOP));
    // R2
    cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/rwc_judge.sv
// rwc_judge: samples the band limits at an accepted start and classifies the
// total when the gate closes. A saturated total or one above the upper limit
// is too slow; otherwise one below the lower limit is too fast; anything else
// is in band. The flags hold until the next result.
// Assumes finish is a one-cycle pulse.
module rwc_judge #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] min_in,
    input  logic [CNT_W-1:0] max_in,
    input  logic             finish,
    input  logic [CNT_W-1:0] tot,
    input  logic             sat,
    output logic             tune_up,
    output logic             tune_down,
    output logic             in_band,
    output logic             done
);
    logic [CNT_W-1:0] min_q, max_q;
    logic             slow, fast;

    // Compare the total against the captured limits.
    always_comb begin
        slow = sat || (tot > max_q);
        fast = !slow && (tot < min_q);
    end

    // Capture the limits on load and write the verdict on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q     <= '0;
            max_q     <= '0;
            tune_up   <= 1'b0;
            tune_down <= 1'b0;
            in_band   <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= finish;
            if (load) begin
                min_q <= min_in;
                max_q <= max_in;
            end
            if (finish) begin
                tune_up   <= slow;
                tune_down <= fast;
                in_band   <= !slow && !fast;
            end
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({tune_up, tune_down, in_band}) == 1));
    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({tune_up, tune_down, in_band}));
    // R4
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tune_up, tune_down, in_band}));
endmodule

// File: rtl/recip_window_cmp.sv
// recip_window_cmp: top of the whole-cycle period window checker. It ties the
// input edge detector, the gate sequencer, the saturating elapsed counter and
// the band judge together.
// Assumes start is honoured only while idle and sig_in is a clean square wave.
module recip_window_cmp #(
    parameter int CNT_W       = 32,
    parameter int CYC_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             start,
    input  logic [CNT_W-1:0] min_cnt,
    input  logic [CNT_W-1:0] max_cnt,
    input  logic [CYC_W-1:0] cyc_num,
    output logic             tune_up,
    output logic             tune_down,
    output logic             in_band,
    output logic             done
);
    logic             rise, load, arm_hit, run, finish, sat;
    logic [CNT_W-1:0] tot;

    rwc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .rise(rise)
    );

    rwc_gate #(.CYC_W(CYC_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .start(start), .cyc_num(cyc_num),
        .rise(rise), .load(load), .arm_hit(arm_hit), .run(run), .finish(finish)
    );

    rwc_elapsed #(.CNT_W(CNT_W)) u_elapsed (
        .clk(clk), .rst_n(rst_n), .clr(arm_hit), .inc(run),
        .tot(tot), .sat(sat)
    );

    rwc_judge #(.CNT_W(CNT_W)) u_judge (
        .clk(clk), .rst_n(rst_n), .load(load), .min_in(min_cnt),
        .max_in(max_cnt), .finish(finish), .tot(tot), .sat(sat),
        .tune_up(tune_up), .tune_down(tune_down), .in_band(in_band),
        .done(done)
    );
endmodule

// File: tb/test_recip_window_cmp.sv
// Bench: random and directed square waves. Expected verdicts come from a
// model of the requirements; outputs are sampled on falling clock edges.
module test_recip_window_cmp;
    localparam int W  = 14;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sig_in = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  min_cnt = '0;
    logic [W-1:0]  max_cnt = '0;
    logic [CW-1:0] cyc_num = '0;
    logic          tune_up, tune_down, in_band, done;

    int   total = 0;
    int   bad = 0;
    int   done_cnt = 0;
    logic [2:0] cap_flags = 3'b000;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    recip_window_cmp #(.CNT_W(W), .CYC_W(CW), .SYNC_STAGES(2)) i_recip_window_cmp (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .start(start),
        .min_cnt(min_cnt), .max_cnt(max_cnt), .cyc_num(cyc_num),
        .tune_up(tune_up), .tune_down(tune_down), .in_band(in_band),
        .done(done)
    );

    // Count done pulses and capture the flags seen with each one.
    always @(negedge clk) begin
        if (done) begin
            done_cnt  <= done_cnt + 1;
            cap_flags <= {tune_up, tune_down, in_band};
        end
    end

    // Expected {up, down, band} from the requirements.
    function automatic logic [2:0] expect_flags(longint t, longint mn, longint mx);
        longint top = (longint'(1) << W) - 1;
        if (t >= top) return 3'b100;
        if (t > mx)   return 3'b100;
        if (t < mn)   return 3'b010;
        return 3'b001;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One measurement: p clocks per period, n loaded periods, optional start poke.
    task automatic measure(string tag, int p, int n, longint mn, longint mx, bit poke);
        int nd = (n == 0) ? 1 : n;
        int d0;
        logic [2:0] exp;
        @(negedge clk);
        min_cnt = W'(mn); max_cnt = W'(mx); cyc_num = CW'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        d0 = done_cnt;
        for (int k = 0; k <= nd; k++) begin
            sig_in = 1'b1;
            if (poke && k == 1) begin
                start = 1'b1; min_cnt = '0; max_cnt = '0; cyc_num = CW'(200);
            end
            @(negedge clk);
            start = 1'b0;
            repeat (p/2 - 1) @(negedge clk);
            sig_in = 1'b0;
            repeat (p - p/2) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        exp = expect_flags(longint'(nd) * p, mn, mx);
        check({tag, " R8 done count"}, done_cnt - d0, 1);
        check({tag, " verdict at done"}, cap_flags, exp);
        check({tag, " R9 verdict held"}, {tune_up, tune_down, in_band}, exp);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 flags after reset", {tune_up, tune_down, in_band, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", {tune_up, tune_down, in_band, done}, 0);

        // R6 R2: total 40 exactly on both limits
        measure("R6 exact band", 10, 4, 40, 40, 1'b0);
        // R4: one above the upper limit
        measure("R4 above max", 10, 4, 0, 39, 1'b0);
        // R5: one below the lower limit
        measure("R5 below min", 10, 4, 41, 60, 1'b0);
        // R3: zero count means one period of 12
        measure("R3 zero count", 12, 0, 12, 12, 1'b0);
        // R10: start during a running measurement is ignored
        measure("R10 busy start", 20, 3, 55, 65, 1'b1);
        // R7: total 18000 saturates the 14-bit counter, max all ones
        measure("R7 saturation", 9000, 2, 0, (longint'(1) << W) - 1, 1'b0);

        // R2 R4 R5 R6: random periods, counts and bands
        for (int i = 0; i < 30; i++) begin
            int p = 4 + int'($urandom_range(0, 96));
            int n = int'($urandom_range(1, 8));
            longint t = longint'(n) * p;
            longint mn, mx;
            int mode = int'($urandom_range(0, 2));
            if (mode == 0) begin
                mn = t - $urandom_range(0, 3);
                mx = t + $urandom_range(0, 20);
            end else if (mode == 1) begin
                mn = 0;
                mx = t - 1 - $urandom_range(0, 3);
            end else begin
                mn = t + 1 + $urandom_range(0, 50);
                mx = mn + 100;
            end
            measure("R2 random", p, n, mn, mx, (i % 7) == 3);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule